// File: doc/BRIEF.md
# Eight-Channel Biphase Audio Stream Receiver

This block takes a single biphase-mark-coded line carrying a 192 kHz AES3-style stream and recovers eight 22-bit audio channels from it. The line is sampled with a fixed number of clock cycles per biphase half-cell. The block re-aligns its sampling phase on every line transition and recognises the three preamble shapes by their coding violations. It then decodes the 28 data slots of each subframe and checks even parity. Each audio word is steered to one of eight channel registers.

Channel alignment does not depend on block-start preambles. Slots 4 and 5 of each subframe carry a 2-bit pair number. A pair is written out only when two subframes that follow each other carry the same number. The channel-status bit of the first subframe in each frame is gathered over a 192-frame block and presented as one parallel word. A lock flag and a sticky parity flag report the health of the link.

Top module: `biphase_octo_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `audio_out`, `cs_word`, `pair_ready`, `cs_valid`, `locked` and `parity_err` are all zero.
- R2: A preamble is accepted only when 8 consecutive half-cells equal 11101000 (block start), 11100010 (first subframe), 11100100 (second subframe), or the bitwise inverse of one of these. The first half-cell must also differ from the half-cell before it. After a preamble, the next 56 half-cells are decoded as slots 4 to 31, where a slot is 1 when its two halves differ.
- R3: Slot 4 is pair-number bit 0 and slot 5 is bit 1. Slots 6 to 27 are audio bits 2 to 23 of the 24-bit output word, lowest first. Bits 1:0 of every output word are zero. Slot 30 is the channel-status bit.
- R4: A parity-good subframe with pair number n writes channels only when the previous subframe was parity-good, carried the same n, and no lock loss came between them. The earlier word then goes to channel 2n+1 and the later word to channel 2n+2. Channel k occupies `audio_out[(k-1)*24 +: 24]`. All other channels keep their values.
- R5: `pair_ready` is high for exactly one clock, in the clock where the channel 7/8 pair is written, and is low otherwise.
- R6: A subframe is discarded when slots 4 to 31 hold an odd number of ones. It changes no channel, it breaks the pairing with the next subframe, and it sets `parity_err`. That flag stays high until reset.
- R7: `locked` rises with the fourth consecutive parity-good subframe. A discarded subframe restarts this count but does not clear `locked`.
- R8: If the 8 half-cells after a subframe do not form a valid preamble, `locked` falls, the pairing memory and the lock count are cleared, and the block hunts for a fresh preamble.
- R9: A block-start subframe restarts channel-status capture with its slot-30 bit as word bit 0. Each following first-subframe preamble frame adds the next bit. When the 192nd bit arrives, `cs_word` is loaded and `cs_valid` pulses for one clock.
- R10: With OSR clocks per half-cell, every output change caused by a subframe appears on the (OSR/2+4)-th rising clock edge after the line starts its final half-cell. A lock loss appears the same number of edges after the start of the eighth half-cell that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR cycles per half-cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| bmc_in | input | 1 | Biphase-mark-coded line |
| audio_out | output | 192 | Eight 24-bit channel words, channel 1 in the lowest bits |
| pair_ready | output | 1 | One-clock pulse on the channel 7/8 write |
| parity_err | output | 1 | Sticky flag for a subframe with a parity error |
| locked | output | 1 | Link lock flag |
| cs_word | output | CS_BITS | Captured channel-status word, bit 0 first in time |
| cs_valid | output | 1 | One-clock pulse when `cs_word` is loaded |

## Verification
Several functions resolve in the same decision clock. On a first subframe that carries a bad parity bit, the sticky flag rises in the same clock as that subframe's channel-status bit enters the block word, and the pairing memory is cleared. In the fourth good subframe, the lock flag rises in the same clock as the channel 3/4 pair is written. The bench injects these cases into a full 192-frame block. A reference model, clocked one step at a time, predicts every output for every clock. It therefore judges both the coincidence and the exact edge at which each effect appears.

// File: rtl/biphase_octo_rx.sv
module biphase_octo_rx #(
  parameter int OSR     = 4,
  parameter int CS_BITS = 192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bmc_in,
  output logic [191:0]       audio_out,
  output logic               pair_ready,
  output logic               parity_err,
  output logic               locked,
  output logic [CS_BITS-1:0] cs_word,
  output logic               cs_valid
);
  localparam int PW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int DH   = 56;
  localparam int FW   = $clog2(CS_BITS);
  localparam logic [1:0] PT_Z = 2'd0, PT_X = 2'd1, PT_Y = 2'd2;

  typedef enum logic [1:0] {HUNT, DATA, GAP} st_t;

  st_t          st;
  logic [2:0]   sy;
  logic [PW-1:0] ph;
  logic [8:0]   win;
  logic [26:0]  sr;
  logic [5:0]   hc;
  logic [2:0]   gc;
  logic [1:0]   gcnt, ptype;
  logic         prev_ok, armed;
  logic [1:0]   prev_idx;
  logic [21:0]  prev_aud;
  logic [FW-1:0] fcnt;
  logic [CS_BITS-1:0] cs_sh;
  logic [7:0][23:0] ch;

  wire flip = sy[1] ^ sy[2];
  wire tick = (ph == PW'(HALF)) && !flip;
  wire [8:0] nw = {win[7:0], sy[2]};
  wire [7:0] pp = nw[7] ? nw[7:0] : ~nw[7:0];
  wire is_z = pp == 8'hE8;
  wire is_x = pp == 8'hE2;
  wire is_y = pp == 8'hE4;
  wire pre_ok = (nw[8] ^ nw[7]) && (is_z || is_x || is_y);
  wire [1:0] pt = is_z ? PT_Z : (is_x ? PT_X : PT_Y);
  wire sbit = sy[2] ^ win[0];
  wire [27:0] w = {sbit, sr};
  wire good = ~^w;
  wire [1:0] idx = w[1:0];
  wire [21:0] aud = w[23:2];
  wire cbit = w[26];
  wire dec = tick && (st == DATA) && (hc == 6'(DH - 1));
  wire [CS_BITS-1:0] cs_next = {cbit, cs_sh[CS_BITS-1:1]};

  assign audio_out = ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT; sy <= '0; ph <= '0; win <= '0; sr <= '0; hc <= '0; gc <= '0;
      gcnt <= '0; ptype <= PT_Y; prev_ok <= 1'b0; armed <= 1'b0; prev_idx <= '0;
      prev_aud <= '0; fcnt <= '0; cs_sh <= '0; ch <= '0; pair_ready <= 1'b0;
      parity_err <= 1'b0; locked <= 1'b0; cs_word <= '0; cs_valid <= 1'b0;
    end else begin
      sy <= {sy[1:0], bmc_in};
      ph <= (flip || ph == PW'(OSR - 1)) ? '0 : ph + PW'(1);
      pair_ready <= 1'b0;
      cs_valid <= 1'b0;
      if (tick) begin
        win <= nw;
        if (hc[0]) sr <= {sbit, sr[26:1]};
        case (st)
          HUNT: if (pre_ok) begin
            st <= DATA; hc <= '0; ptype <= pt;
          end
          DATA: begin
            hc <= hc + 6'd1;
            if (hc == 6'(DH - 1)) begin
              st <= GAP; gc <= '0;
              if (good) begin
                if (prev_ok && prev_idx == idx) begin
                  ch[{idx, 1'b0}] <= {prev_aud, 2'b00};
                  ch[{idx, 1'b1}] <= {aud, 2'b00};
                  if (idx == 2'd3) pair_ready <= 1'b1;
                end
                prev_ok <= 1'b1; prev_idx <= idx; prev_aud <= aud;
                if (gcnt == 2'd3) locked <= 1'b1;
                else gcnt <= gcnt + 2'd1;
              end else begin
                prev_ok <= 1'b0; gcnt <= '0; parity_err <= 1'b1;
              end
              if (ptype == PT_Z) begin
                cs_sh <= cs_next; fcnt <= FW'(1); armed <= 1'b1;
              end else if (ptype == PT_X && armed) begin
                cs_sh <= cs_next;
                if (fcnt == FW'(CS_BITS - 1)) begin
                  cs_word <= cs_next; cs_valid <= 1'b1; armed <= 1'b0;
                end else fcnt <= fcnt + FW'(1);
              end
            end
          end
          default: begin
            gc <= gc + 3'd1;
            if (gc == 3'd7) begin
              if (pre_ok) begin
                st <= DATA; hc <= '0; ptype <= pt;
              end else begin
                st <= HUNT; locked <= 1'b0; prev_ok <= 1'b0; gcnt <= '0; armed <= 1'b0;
              end
            end
          end
        endcase
      end
    end
  end

  p_ready_one_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready |=> !pair_ready);
  p_perr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> parity_err);
  p_ch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(audio_out) |-> $past(dec && good));
  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(st) == DATA && $past(tick)));
  p_lock_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(st) == GAP);
  p_cs_one_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_valid |=> !cs_valid);
endmodule

// File: tb/sim_biphase_octo_rx.sv
`timescale 1ns/1ps
module sim_biphase_octo_rx;
  localparam int OSR = 4;
  localparam int LAT = OSR / 2 + 4;

  logic clk = 1'b0, rst_n = 1'b0, bmc_in = 1'b0;
  logic [191:0] audio_out;
  logic pair_ready, parity_err, locked, cs_valid;
  logic [191:0] cs_word;

  biphase_octo_rx #(.OSR(OSR), .CS_BITS(192)) u0 (
    .clk(clk), .rst_n(rst_n), .bmc_in(bmc_in), .audio_out(audio_out),
    .pair_ready(pair_ready), .parity_err(parity_err), .locked(locked),
    .cs_word(cs_word), .cs_valid(cs_valid));

  always #2 clk = ~clk;

  int cyc = 0, total = 0, bad = 0;
  always @(posedge clk) cyc++;

  logic [23:0] e_ch [8];
  logic e_ready = 0, e_lock = 0, e_perr = 0, e_csv = 0;
  logic [191:0] e_cs = '0;
  bit m_pok = 0, m_arm = 0;
  logic [1:0] m_pidx = '0;
  logic [21:0] m_paud = '0;
  int m_g = 0;
  bit cs_q[$];

  int sub_due = -1, drop_due = -1, last_fin = 0;
  bit have_sub = 0, mon_on = 0;
  int p_pt; logic [1:0] p_idx; logic [21:0] p_aud; bit p_c, p_bad;
  logic lvl = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic apply_sub();
    if (!p_bad) begin
      if (m_pok && m_pidx == p_idx) begin
        e_ch[2*p_idx] = {m_paud, 2'b00};
        e_ch[2*p_idx+1] = {p_aud, 2'b00};
        if (p_idx == 2'd3) e_ready = 1;
      end
      m_pok = 1; m_pidx = p_idx; m_paud = p_aud;
      if (m_g == 3) e_lock = 1; else m_g++;
    end else begin
      m_pok = 0; m_g = 0; e_perr = 1;
    end
    if (p_pt == 0) begin
      cs_q.delete(); cs_q.push_back(p_c); m_arm = 1;
    end else if (p_pt == 1 && m_arm) begin
      cs_q.push_back(p_c);
      if (cs_q.size() == 192) begin
        for (int i = 0; i < 192; i++) e_cs[i] = cs_q[i];
        e_csv = 1; m_arm = 0;
      end
    end
  endtask

  always @(negedge clk) begin
    e_ready = 0; e_csv = 0;
    if (cyc == sub_due) apply_sub();
    if (cyc == drop_due) begin
      e_lock = 0; m_pok = 0; m_g = 0; m_arm = 0;
    end
    if (mon_on) begin
      for (int i = 0; i < 8; i++)
        chk(audio_out[i*24 +: 24] === e_ch[i], "R3/R4/R10 channel word", 192'(audio_out[i*24 +: 24]), 192'(e_ch[i]));
      chk(pair_ready === e_ready, "R5 pair_ready", 192'(pair_ready), 192'(e_ready));
      chk(locked === e_lock, "R2/R7/R8 locked", 192'(locked), 192'(e_lock));
      chk(parity_err === e_perr, "R6 parity_err", 192'(parity_err), 192'(e_perr));
      chk(cs_valid === e_csv, "R9 cs_valid", 192'(cs_valid), 192'(e_csv));
      chk(cs_word === e_cs, "R9 cs_word", cs_word, e_cs);
    end
  end

  task automatic half(input logic b);
    bmc_in = b; lvl = b;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic idle(input int n);
    if (have_sub) begin
      drop_due = last_fin + 8*OSR + LAT; have_sub = 0;
    end
    repeat (n) half(lvl);
  endtask

  task automatic send_sub(input int pt, input logic [1:0] idx, input logic [21:0] a, input bit c, input bit badp);
    logic [7:0] pat;
    logic [27:0] w;
    pat = (pt == 0) ? 8'hE8 : ((pt == 1) ? 8'hE2 : 8'hE4);
    if (lvl) pat = ~pat;
    for (int i = 7; i >= 0; i--) half(pat[i]);
    w = {1'b0, c, 1'b0, 1'b1, a, idx};
    w[27] = (^w[26:0]) ^ badp;
    for (int k = 0; k < 28; k++) begin
      half(~lvl);
      if (k == 27) begin
        p_pt = pt; p_idx = idx; p_aud = a; p_c = c; p_bad = badp;
        sub_due = cyc + LAT; last_fin = cyc; have_sub = 1;
      end
      half(w[k] ? ~lvl : lvl);
    end
  endtask

  function automatic logic [21:0] aud(input int f, input int s);
    return 22'((f * 32'h1357B) ^ (s * 32'h2A5A5) ^ 32'h15);
  endfunction

  function automatic bit cbit(input int f);
    return ((f * 5 + 1) % 7) < 3;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) e_ch[i] = '0;
    repeat (3) @(negedge clk);
    chk(audio_out === '0 && cs_word === '0, "R1 words in reset", audio_out, '0);
    chk({pair_ready, cs_valid, locked, parity_err} === 4'b0, "R1 flags in reset",
        192'({pair_ready, cs_valid, locked, parity_err}), '0);
    rst_n = 1'b1;
    mon_on = 1;
    idle(16);
    for (int f = 0; f < 192; f++) begin
      logic [1:0] ia, ib;
      ia = 2'(f % 4); ib = ia;
      if (f == 40) begin ia = 2'd1; ib = 2'd2; end
      if (f == 51) ia = 2'd2;
      send_sub(f == 0 ? 0 : 1, ia, aud(f, 0), cbit(f), f == 60);
      send_sub(2, ib, aud(f, 1), f[0], f == 20);
    end
    repeat (2) @(negedge clk);
    chk(cs_word[0] === cbit(0) && cs_word[191] === cbit(191), "R9 word ends",
        192'({cs_word[191], cs_word[0]}), 192'({cbit(191), cbit(0)}));
    idle(12);
    chk(locked === 1'b0, "R8 lock lost after missing preamble", 192'(locked), 192'(0));
    for (int g = 0; g < 6; g++) begin
      logic [1:0] ix;
      ix = (g == 0) ? 2'd3 : 2'(g % 4);
      send_sub(g == 0 ? 0 : 1, ix, aud(g + 300, 0), cbit(g), 1'b0);
      send_sub(2, ix, aud(g + 300, 1), 1'b0, 1'b0);
    end
    chk(locked === 1'b1, "R7 relock", 192'(locked), 192'(1));
    idle(12);
    repeat (10) @(negedge clk);
    mon_on = 0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(parity_err === 1'b0 && locked === 1'b0, "R6/R1 flags cleared by reset",
        192'({parity_err, locked}), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule